// File: doc/BRIEF.md
# In-Order Memory Completion Buffer

This block sits between the issue stage of a vector memory pipeline and the stage that writes load results back. Each memory instruction is given a slot when it is issued, tagged with the next sequence number in a strictly increasing series. Responses from the memory side may come back in any order. Each response names the tag it belongs to and marks that slot complete. The retire port only ever shows the oldest outstanding instruction, and only after that instruction is complete. Downstream logic therefore sees completions in program order.

Some instructions are complete as soon as they are issued. A load or store with every lane inactive sends nothing to memory, so its slot is marked complete at issue and it still retires in its proper place. A fence waits for a response like any other instruction. An end-of-kernel marker is accepted but takes no slot and uses up no tag. A response aimed at a slot that is not outstanding, or at one that is already complete, raises a one-cycle error flag and changes nothing.

The slot index is the low bits of the tag. The buffer is a ring of `DEPTH` slots. Operation kinds are encoded as load = 0, store = 1, fence = 2 and end-of-kernel = 3.

Top module: `ordbuf_cmpl`

## Requirements
- R1: During and after synchronous reset the buffer is empty, so `ret_valid` = 0 and `rsp_err` = 0, and `iss_ready` = 1 for a load that carries tag 0.
- R2: When `DEPTH` slots are occupied, `iss_ready` is 0 for kinds 0, 1 and 2.
- R3: An issue of kind 3 (end-of-kernel) is always accepted, even when the buffer is full. It takes no slot, never appears at retire, and does not advance the expected tag.
- R4: A response whose tag is outstanding marks that slot complete at the next clock edge. `ret_valid` stays 0 while the oldest slot is incomplete.
- R5: Slots retire in strictly increasing tag order, whatever order their responses arrive in. A later slot that is complete waits behind an earlier slot that is not.
- R6: A load or store issued with `iss_nolanes` = 1 is complete at issue. If it is the oldest slot, `ret_valid` is 1 in the cycle after the issue, with no response.
- R7: A fence issued with `iss_nolanes` = 1 is not complete at issue. It waits for its response.
- R8: While `ret_valid` = 1 and `wb_rdy` = 0, the oldest slot stays presented with `ret_seq` and `ret_kind` unchanged. A cycle with both high removes exactly that slot.
- R9: A response whose tag is outside the outstanding window, or whose slot is already complete, sets `rsp_err` to 1 for the single cycle after it and changes no slot.
- R10: `ret_kind` reports the kind (0, 1 or 2) given at issue for the slot being presented. `ret_seq` is that slot's tag.
- R11: For kinds 0 to 2, `iss_ready` is 0 unless `iss_seq` equals the next expected tag, which counts up by one for every accepted non-end-of-kernel issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_seq | input | SEQ_W | Tag of the issued instruction |
| iss_kind | input | 2 | 0 load, 1 store, 2 fence, 3 end-of-kernel |
| iss_nolanes | input | 1 | Instruction has no active lanes |
| rsp_valid | input | 1 | Memory response present |
| rsp_seq | input | SEQ_W | Tag of the response |
| rsp_err | output | 1 | Previous-cycle response was illegal |
| ret_valid | output | 1 | Oldest slot is complete and presented |
| wb_rdy | input | 1 | Write-back stage accepts the retire |
| ret_seq | output | SEQ_W | Tag of the presented slot |
| ret_kind | output | 2 | Kind of the presented slot |

## Verification
The checker takes for granted that the issuer never offers more than one end-of-kernel marker at a time. It also assumes that tags are offered in order, and that a response for a slot never arrives in the same cycle as that slot's issue. The directed stimulus follows these rules. It tracks the next expected tag itself and sends each response at least one cycle after its issue. Responses that break the rules on purpose are sent only in the error scenario: tags that are out of the window, already complete, or already retired. This lets the error flag and the unchanged state be observed at the ports.

// File: rtl/ordbuf_pkg.sv
package ordbuf_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FENCE = 2'd2,
    KIND_EOK   = 2'd3
  } op_kind_e;
endpackage

// File: rtl/ob_ptrs.sv
module ob_ptrs #(
  parameter int SEQ_W = 8,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [SEQ_W-1:0] head_seq,
  output logic [SEQ_W-1:0] tail_seq,
  output logic [CNT_W-1:0] occ,
  output logic             full,
  output logic             empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      head_seq <= '0;
      tail_seq <= '0;
      occ      <= '0;
    end else begin
      if (push) tail_seq <= tail_seq + 1'b1;
      if (pop)  head_seq <= head_seq + 1'b1;
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign full  = (occ == CNT_W'(DEPTH));
  assign empty = (occ == '0);
endmodule

// File: rtl/ob_done_flags.sv
module ob_done_flags #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             alloc_done,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx,
  output logic [DEPTH-1:0] done_vec
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        done_vec[i] <= 1'b0;
      end else if (alloc_en && (alloc_idx == IDX_W'(i))) begin
        done_vec[i] <= alloc_done;
      end else if (mark_en && (mark_idx == IDX_W'(i))) begin
        done_vec[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ob_kind_ram.sv
module ob_kind_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ordbuf_cmpl.sv
module ordbuf_cmpl
  import ordbuf_pkg::*;
#(
  parameter int SEQ_W = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic [1:0]       iss_kind,
  input  logic             iss_nolanes,
  input  logic             rsp_valid,
  input  logic [SEQ_W-1:0] rsp_seq,
  output logic             rsp_err,
  output logic             ret_valid,
  input  logic             wb_rdy,
  output logic [SEQ_W-1:0] ret_seq,
  output logic [1:0]       ret_kind
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [SEQ_W-1:0] head_seq, tail_seq;
  logic [CNT_W-1:0] occ;
  logic             full, empty;
  logic [DEPTH-1:0] done_vec;

  op_kind_e kind;
  logic     is_eok, alloc, alloc_done;
  logic     ret_fire;

  assign kind   = op_kind_e'(iss_kind);
  assign is_eok = (kind == KIND_EOK);

  // issue side: end-of-kernel always passes, others need room and the right tag
  assign iss_ready  = is_eok || (!full && (iss_seq == tail_seq));
  assign alloc      = iss_valid && iss_ready && !is_eok;
  assign alloc_done = iss_nolanes && ((kind == KIND_LOAD) || (kind == KIND_STORE));

  // response side: tag must lie in [head, head+occ) and slot must be pending
  logic [SEQ_W-1:0] rsp_dist;
  logic [IDX_W-1:0] rsp_idx;
  logic             rsp_in_win, rsp_ok;

  assign rsp_dist   = rsp_seq - head_seq;
  assign rsp_idx    = rsp_seq[IDX_W-1:0];
  assign rsp_in_win = (rsp_dist < SEQ_W'(occ));
  assign rsp_ok     = rsp_in_win && !done_vec[rsp_idx];

  always_ff @(posedge clk) begin
    if (rst) rsp_err <= 1'b0;
    else     rsp_err <= rsp_valid && !rsp_ok;
  end

  // retire side
  logic [IDX_W-1:0] head_idx;
  assign head_idx  = head_seq[IDX_W-1:0];
  assign ret_valid = !empty && done_vec[head_idx];
  assign ret_fire  = ret_valid && wb_rdy;
  assign ret_seq   = head_seq;

  ob_ptrs #(.SEQ_W(SEQ_W), .DEPTH(DEPTH)) ptrs_i (
    .clk      (clk),
    .rst      (rst),
    .push     (alloc),
    .pop      (ret_fire),
    .head_seq (head_seq),
    .tail_seq (tail_seq),
    .occ      (occ),
    .full     (full),
    .empty    (empty)
  );

  ob_done_flags #(.DEPTH(DEPTH)) flags_i (
    .clk        (clk),
    .rst        (rst),
    .alloc_en   (alloc),
    .alloc_idx  (iss_seq[IDX_W-1:0]),
    .alloc_done (alloc_done),
    .mark_en    (rsp_valid && rsp_ok),
    .mark_idx   (rsp_idx),
    .done_vec   (done_vec)
  );

  ob_kind_ram #(.DEPTH(DEPTH), .W(2)) kinds_i (
    .clk   (clk),
    .we    (alloc),
    .waddr (iss_seq[IDX_W-1:0]),
    .wdata (iss_kind),
    .raddr (head_idx),
    .rdata (ret_kind)
  );
endmodule

// File: rtl/ordbuf_cmpl_chk.sv
module ordbuf_cmpl_chk #(
  parameter int SEQ_W = 8,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [1:0]       iss_kind,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic             ret_valid,
  input logic             wb_rdy,
  input logic [SEQ_W-1:0] ret_seq,
  input logic [1:0]       ret_kind,
  input logic [CNT_W-1:0] occ
);
  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    // R1
    if (rst_q) begin
      reset_state_chk: assert (!ret_valid && !rsp_err && occ == '0);
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  // R2
  full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == CNT_W'(DEPTH) && iss_kind != 2'd3) |-> !iss_ready);

  // R2
  alloc_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready && iss_kind != 2'd3 && !(ret_valid && wb_rdy))
      |=> occ == $past(occ) + 1'b1);

  // R3
  eok_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_kind == 2'd3) |-> iss_ready);

  // R3
  eok_no_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_kind == 2'd3 && !(ret_valid && wb_rdy)) |=> $stable(occ));

  // R4
  empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    occ == '0 |-> !ret_valid);

  // R5
  retire_order_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && wb_rdy) |=> ret_seq == $past(ret_seq) + 1'b1);

  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !wb_rdy) |=> ret_valid && $stable(ret_seq) && $stable(ret_kind));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(rsp_valid));
endmodule

bind ordbuf_cmpl ordbuf_cmpl_chk #(.SEQ_W(SEQ_W), .DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_kind  (iss_kind),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .ret_valid (ret_valid),
  .wb_rdy    (wb_rdy),
  .ret_seq   (ret_seq),
  .ret_kind  (ret_kind),
  .occ       (occ)
);

// File: tb/ordbuf_cmpl_tb_top.sv
`timescale 1ns/1ps
module ordbuf_cmpl_tb_top;
  localparam int SEQ_W = 8;
  localparam int DEPTH = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             iss_valid = 1'b0;
  logic             iss_ready;
  logic [SEQ_W-1:0] iss_seq = '0;
  logic [1:0]       iss_kind = 2'd0;
  logic             iss_nolanes = 1'b0;
  logic             rsp_valid = 1'b0;
  logic [SEQ_W-1:0] rsp_seq = '0;
  logic             rsp_err;
  logic             ret_valid;
  logic             wb_rdy = 1'b0;
  logic [SEQ_W-1:0] ret_seq;
  logic [1:0]       ret_kind;

  int total = 0;
  int bad   = 0;
  int nseq  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ordbuf_cmpl #(.SEQ_W(SEQ_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_seq(iss_seq),
    .iss_kind(iss_kind), .iss_nolanes(iss_nolanes),
    .rsp_valid(rsp_valid), .rsp_seq(rsp_seq), .rsp_err(rsp_err),
    .ret_valid(ret_valid), .wb_rdy(wb_rdy), .ret_seq(ret_seq), .ret_kind(ret_kind)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // offer one issue for a single cycle; tag defaults to the expected one
  task automatic issue(input logic [1:0] k, input logic nl, input logic exp_rdy,
                       input int tag = -1);
    iss_valid   = 1'b1;
    iss_kind    = k;
    iss_nolanes = nl;
    iss_seq     = (tag < 0) ? SEQ_W'(nseq) : SEQ_W'(tag);
    #1;
    chk("R2/R3/R11 iss_ready", {31'd0, iss_ready}, {31'd0, exp_rdy});
    cyc();
    if (exp_rdy && k != 2'd3) nseq++;
    iss_valid   = 1'b0;
    iss_kind    = 2'd0;
    iss_nolanes = 1'b0;
  endtask

  task automatic respond(input int tag, input logic exp_err);
    rsp_valid = 1'b1;
    rsp_seq   = SEQ_W'(tag);
    cyc();
    rsp_valid = 1'b0;
    chk("R9 rsp_err", {31'd0, rsp_err}, {31'd0, exp_err});
  endtask

  task automatic retire(input int tag, input logic [1:0] k);
    wb_rdy = 1'b1;
    #1;
    chk("R4 ret_valid", {31'd0, ret_valid}, 32'd1);
    chk("R5 ret_seq", {24'd0, ret_seq}, tag);
    chk("R10 ret_kind", {30'd0, ret_kind}, {30'd0, k});
    cyc();
    wb_rdy = 1'b0;
  endtask

  task automatic t_reset();
    iss_kind = 2'd0;
    iss_seq  = '0;
    #1;
    chk("R1 ret_valid", {31'd0, ret_valid}, 32'd0);
    chk("R1 rsp_err", {31'd0, rsp_err}, 32'd0);
    chk("R1 iss_ready", {31'd0, iss_ready}, 32'd1);
  endtask

  task automatic t_inorder();
    int b = nseq;
    issue(2'd0, 1'b0, 1'b1);
    issue(2'd1, 1'b0, 1'b1);
    issue(2'd2, 1'b0, 1'b1);
    chk("R4 not done yet", {31'd0, ret_valid}, 32'd0);
    respond(b, 1'b0);
    chk("R4 done after rsp", {31'd0, ret_valid}, 32'd1);
    respond(b + 1, 1'b0);
    respond(b + 2, 1'b0);
    retire(b, 2'd0);
    retire(b + 1, 2'd1);
    retire(b + 2, 2'd2);
    chk("R8 one per handshake", {31'd0, ret_valid}, 32'd0);
  endtask

  task automatic t_ooo();
    int b = nseq;
    for (int i = 0; i < 4; i++) issue(2'd0, 1'b0, 1'b1);
    respond(b + 3, 1'b0);
    chk("R5 younger waits", {31'd0, ret_valid}, 32'd0);
    respond(b + 1, 1'b0);
    respond(b + 2, 1'b0);
    chk("R5 head still pending", {31'd0, ret_valid}, 32'd0);
    respond(b, 1'b0);
    for (int i = 0; i < 4; i++) retire(b + i, 2'd0);
  endtask

  task automatic t_hold();
    int b = nseq;
    issue(2'd1, 1'b0, 1'b1);
    respond(b, 1'b0);
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R8 held valid", {31'd0, ret_valid}, 32'd1);
      chk("R8 held seq", {24'd0, ret_seq}, b);
      chk("R8 held kind", {30'd0, ret_kind}, 32'd1);
    end
    retire(b, 2'd1);
    chk("R8 removed", {31'd0, ret_valid}, 32'd0);
  endtask

  task automatic t_nolanes();
    int b = nseq;
    issue(2'd0, 1'b1, 1'b1);
    chk("R6 load done at issue", {31'd0, ret_valid}, 32'd1);
    retire(b, 2'd0);
    issue(2'd1, 1'b1, 1'b1);
    chk("R6 store done at issue", {31'd0, ret_valid}, 32'd1);
    retire(b + 1, 2'd1);
    issue(2'd2, 1'b1, 1'b1);
    cyc();
    chk("R7 fence waits", {31'd0, ret_valid}, 32'd0);
    respond(b + 2, 1'b0);
    retire(b + 2, 2'd2);
  endtask

  task automatic t_eok();
    int b = nseq;
    issue(2'd3, 1'b0, 1'b1, 8'hAA);
    chk("R3 no entry", {31'd0, ret_valid}, 32'd0);
    issue(2'd0, 1'b0, 1'b1);
    respond(b, 1'b0);
    retire(b, 2'd0);
    chk("R3 nothing behind", {31'd0, ret_valid}, 32'd0);
  endtask

  task automatic t_badtag();
    int b = nseq;
    issue(2'd0, 1'b0, 1'b0, b + 1);
    issue(2'd1, 1'b0, 1'b0, b - 1);
    issue(2'd0, 1'b0, 1'b1);
    respond(b, 1'b0);
    retire(b, 2'd0);
    chk("R11 only one slot", {31'd0, ret_valid}, 32'd0);
  endtask

  task automatic t_err();
    int b = nseq;
    respond(b, 1'b1);
    cyc();
    chk("R9 err one cycle", {31'd0, rsp_err}, 32'd0);
    issue(2'd0, 1'b0, 1'b1);
    chk("R9 bad rsp left slot pending", {31'd0, ret_valid}, 32'd0);
    respond(b, 1'b0);
    chk("R9 good rsp", {31'd0, ret_valid}, 32'd1);
    respond(b, 1'b1);
    chk("R9 dup keeps head", {24'd0, ret_seq}, b);
    retire(b, 2'd0);
    respond(b, 1'b1);
    respond(b - 5, 1'b1);
  endtask

  task automatic t_full();
    int b = nseq;
    for (int i = 0; i < DEPTH; i++) issue(2'd1, 1'b0, 1'b1);
    issue(2'd0, 1'b0, 1'b0);
    issue(2'd2, 1'b0, 1'b0);
    issue(2'd3, 1'b0, 1'b1, 8'h55);
    chk("R3 eok when full", {31'd0, ret_valid}, 32'd0);
    for (int i = DEPTH - 1; i >= 0; i--) respond(b + i, 1'b0);
    for (int i = 0; i < DEPTH; i++) retire(b + i, 2'd1);
    chk("R2 drained", {31'd0, ret_valid}, 32'd0);
    issue(2'd0, 1'b0, 1'b1);
    respond(b + DEPTH, 1'b0);
    retire(b + DEPTH, 2'd0);
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    rst = 1'b0;
    cyc();
    t_reset();
    t_inorder();
    t_ooo();
    t_hold();
    t_nolanes();
    t_eok();
    t_badtag();
    t_err();
    t_full();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule